// File: doc/BRIEF.md
# Soft Mute Ramp Sequencer with Decoder Mute Interlock

This block produces the gain coefficient used by a downstream audio multiplier to fade the signal out and back in without clicks. A mute is asked for either by an external active-low mute pin or by a software enable bit. Once asked, the block walks an unsigned gain word from full scale down to zero along an S-shaped curve. The curve moves slowly near both ends and fastest in the middle. When the request goes away, the block walks the gain back up the same way. A two-bit selector picks one of four ramp durations, nominally 0.48 ms, 0.96 ms, 40.4 ms and 324 ms at the default clock. A ramp that has started always runs to its end.

The block also drives a mute line for the stereo decoder. When decoder influence is enabled and the decoder is the selected audio source, the decoder is muted once the audio has faded fully out. It is let go the moment the unmute begins, before any gain is restored. The decoder line is always held when a forced-mute bit is set, or when some other source is selected. A busy flag covers the whole interval from the start of the fade-out to the end of the fade-in.

The curve is stored as NPTS points of a cubic smoothstep. Each gap between points is split into 2^SUB_W linear sub-steps. This gives PMAX = (NPTS-1)·2^SUB_W steps per ramp: 124 steps with the defaults.

Top module: `smute_seq`

## Requirements
- R1: After synchronous reset the block is idle: `gain` is all ones (full scale), `busy` is 0, and `dec_mute` equals `dec_force | ~src_is_dec`.
- R2: A mute request is `~mute_pin_n | mute_en`. On the first clock edge at which an idle block sees a request, the fall ramp starts and `busy` reads 1 from that edge on. With no request, the idle block leaves `gain` at full scale and `busy` at 0.
- R3: The ramp speed is set by `time_sel`. The values 0, 1, 2 and 3 select DIV0, DIV1, DIV2 and DIV3 clocks per step. A ramp that starts at edge E0 has moved to step position floor(k/DIV) at edge E0+k, so a whole ramp takes PMAX·DIV clocks.
- R4: Curve point j (0..NPTS-1), with L = NPTS-1 and FULL = 2^GAIN_W-1, is floor(FULL·(3j²L − 2j³)/L³). At position p, with i = p>>SUB_W and f = p mod 2^SUB_W, the gain is P(i) + floor((P(i+1)−P(i))·f/2^SUB_W). P(i+1) is replaced by P(i) when i = L. The fall ramp runs p from PMAX down to 0, and the rise ramp runs p from 0 up to PMAX.
- R5: A started ramp cannot be interrupted. Removing the request during a fall still brings the gain to 0, and a rise then follows at once. Raising the request during a rise still brings the gain to full scale, and a new fall then follows at once.
- R6: `busy` is 1 from the fall start through the muted hold, and for the whole rise. It drops to 0 at the edge where the gain returns to full scale.
- R7: When `dec_infl` and `src_is_dec` are both 1, `dec_mute` is 1 while the gain rests at 0 after a fall. When `dec_infl` is 0, the fall alone does not raise `dec_mute`.
- R8: At the edge where the rise starts, `dec_mute` returns to `dec_force | ~src_is_dec` while `gain` is still 0.
- R9: While `dec_force` is 1, `dec_mute` is 1 in every state.
- R10: While `src_is_dec` is 0, `dec_mute` is 1 in every state.
- R11: `time_sel` is captured when each ramp starts. Changes to it during a ramp do not affect that ramp's step timing.
- R12: During a fall the gain never increases from one clock to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mute_pin_n | input | 1 | External mute request, active low, already synchronised |
| mute_en | input | 1 | Software mute enable |
| time_sel | input | 2 | Ramp duration select |
| dec_infl | input | 1 | Let the soft mute also mute the stereo decoder |
| src_is_dec | input | 1 | Stereo decoder is the selected source |
| dec_force | input | 1 | Hold the decoder muted unconditionally |
| gain | output | GAIN_W | Gain coefficient, full scale = all ones |
| busy | output | 1 | High from mute start until demute end |
| dec_mute | output | 1 | Stereo decoder mute control |

## Verification
The assertions assume the following about the inputs:
- `mute_pin_n` is already synchronous to `clk`.
- Every divisor is at least one, so a step tick can come.
- The decoder-select, influence and force inputs may change at any time, because the block only combines them with its state.

The stimulus meets these assumptions by changing every input half a period away from the active edge. It drives small divisors so that each of the four durations is swept cycle by cycle. It also toggles the request and `time_sel` inside running ramps, to exercise the interruption and capture rules on real edges.

// File: rtl/smute_pkg.sv
`timescale 1ns/1ps
package smute_pkg;

    typedef enum logic [1:0] {
        SM_OPEN = 2'd0,
        SM_FALL = 2'd1,
        SM_SHUT = 2'd2,
        SM_RISE = 2'd3
    } sm_state_e;

    // Cubic smoothstep sample j of a curve with last index lst, scaled to full.
    function automatic longint unsigned s_point(input int j, input int lst,
                                                input longint unsigned full);
        longint unsigned jj;
        longint unsigned ll;
        jj = longint'(j);
        ll = longint'(lst);
        return (full * (3 * jj * jj * ll - 2 * jj * jj * jj)) / (ll * ll * ll);
    endfunction

endpackage

// File: rtl/smute_pacer.sv
`timescale 1ns/1ps
module smute_pacer #(
    parameter int unsigned DIV0 = 48,
    parameter int unsigned DIV1 = 95,
    parameter int unsigned DIV2 = 4004,
    parameter int unsigned DIV3 = 32107
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int unsigned DM01 = (DIV0 > DIV1) ? DIV0 : DIV1;
    localparam int unsigned DM23 = (DIV2 > DIV3) ? DIV2 : DIV3;
    localparam int unsigned DMAX = (DM01 > DM23) ? DM01 : DM23;
    localparam int unsigned CW   = $clog2(DMAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb begin
        unique case (sel)
            2'd0:    lim = CW'(DIV0);
            2'd1:    lim = CW'(DIV1);
            2'd2:    lim = CW'(DIV2);
            default: lim = CW'(DIV3);
        endcase
    end

    assign tick = (cnt == lim - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || restart || tick) cnt <= '0;
        else                        cnt <= cnt + CW'(1);
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt < lim);

endmodule

// File: rtl/smute_shape.sv
`timescale 1ns/1ps
module smute_shape
    import smute_pkg::*;
#(
    parameter int unsigned GAIN_W = 12,
    parameter int unsigned NPTS   = 32,
    parameter int unsigned SUB_W  = 2,
    localparam int unsigned SEG_W = $clog2(NPTS),
    localparam int unsigned POS_W = SEG_W + SUB_W
) (
    input  logic [POS_W-1:0]  pos,
    output logic [GAIN_W-1:0] gain
);
    localparam longint unsigned FULL = (64'd1 << GAIN_W) - 64'd1;

    logic [GAIN_W-1:0] pts [NPTS];

    for (genvar j = 0; j < NPTS; j++) begin : g_pt
        localparam longint unsigned VAL = s_point(j, NPTS - 1, FULL);
        assign pts[j] = GAIN_W'(VAL);
    end

    logic [SEG_W-1:0]        seg, nxt;
    logic [SUB_W-1:0]        frac;
    logic [GAIN_W-1:0]       lo, hi, delta;
    logic [GAIN_W+SUB_W-1:0] prod;

    always_comb begin
        seg   = pos[POS_W-1:SUB_W];
        frac  = pos[SUB_W-1:0];
        nxt   = (seg == SEG_W'(NPTS - 1)) ? seg : seg + SEG_W'(1);
        lo    = pts[seg];
        hi    = pts[nxt];
        delta = hi - lo;
        prod  = {{SUB_W{1'b0}}, delta} * {{GAIN_W{1'b0}}, frac};
        gain  = lo + prod[GAIN_W+SUB_W-1:SUB_W];
    end

endmodule

// File: rtl/smute_ctrl.sv
`timescale 1ns/1ps
module smute_ctrl
    import smute_pkg::*;
#(
    parameter int unsigned POS_W = 7,
    parameter int unsigned PMAX  = 124
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             tick,
    input  logic [1:0]       time_sel,
    output sm_state_e        state,
    output logic [POS_W-1:0] pos,
    output logic [1:0]       tsel_q,
    output logic             restart
);
    always_comb begin
        unique case (state)
            SM_OPEN: restart = req;
            SM_SHUT: restart = ~req;
            default: restart = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SM_OPEN;
            pos    <= POS_W'(PMAX);
            tsel_q <= 2'd0;
        end else begin
            unique case (state)
                SM_OPEN: if (req) begin
                    state  <= SM_FALL;
                    tsel_q <= time_sel;
                end
                SM_FALL: if (tick) begin
                    pos <= pos - POS_W'(1);
                    if (pos == POS_W'(1)) state <= SM_SHUT;
                end
                SM_SHUT: if (!req) begin
                    state  <= SM_RISE;
                    tsel_q <= time_sel;
                end
                default: if (tick) begin
                    pos <= pos + POS_W'(1);
                    if (pos == POS_W'(PMAX - 1)) state <= SM_OPEN;
                end
            endcase
        end
    end

    // R5
    fall_runs_out_chk: assert property (@(posedge clk) disable iff (rst)
        state == SM_FALL |=> state inside {SM_FALL, SM_SHUT});
    // R5
    rise_runs_out_chk: assert property (@(posedge clk) disable iff (rst)
        state == SM_RISE |=> state inside {SM_RISE, SM_OPEN});
    // R11
    tsel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SM_FALL && $past(state) == SM_FALL) |-> $stable(tsel_q));

endmodule

// File: rtl/smute_seq.sv
`timescale 1ns/1ps
module smute_seq
    import smute_pkg::*;
#(
    parameter int unsigned GAIN_W = 12,
    parameter int unsigned NPTS   = 32,
    parameter int unsigned SUB_W  = 2,
    parameter int unsigned DIV0   = 48,
    parameter int unsigned DIV1   = 95,
    parameter int unsigned DIV2   = 4004,
    parameter int unsigned DIV3   = 32107
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mute_pin_n,
    input  logic              mute_en,
    input  logic [1:0]        time_sel,
    input  logic              dec_infl,
    input  logic              src_is_dec,
    input  logic              dec_force,
    output logic [GAIN_W-1:0] gain,
    output logic              busy,
    output logic              dec_mute
);
    localparam int unsigned SEG_W = $clog2(NPTS);
    localparam int unsigned POS_W = SEG_W + SUB_W;
    localparam int unsigned PMAX  = (NPTS - 1) << SUB_W;

    sm_state_e        state;
    logic [POS_W-1:0] pos;
    logic [1:0]       tsel_q;
    logic             restart;
    logic             tick;
    logic             req;

    assign req = ~mute_pin_n | mute_en;

    smute_ctrl #(.POS_W(POS_W), .PMAX(PMAX)) u_ctrl (
        .clk(clk), .rst(rst), .req(req), .tick(tick), .time_sel(time_sel),
        .state(state), .pos(pos), .tsel_q(tsel_q), .restart(restart)
    );

    smute_pacer #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_pacer (
        .clk(clk), .rst(rst), .restart(restart), .sel(tsel_q), .tick(tick)
    );

    smute_shape #(.GAIN_W(GAIN_W), .NPTS(NPTS), .SUB_W(SUB_W)) u_shape (
        .pos(pos), .gain(gain)
    );

    assign busy     = (state != SM_OPEN);
    assign dec_mute = dec_force | ~src_is_dec | (dec_infl & (state == SM_SHUT));

    // R12
    gain_fall_mono_chk: assert property (@(posedge clk) disable iff (rst)
        state == SM_FALL |=> gain <= $past(gain));
    // R6
    busy_end_full_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> gain == {GAIN_W{1'b1}});
    // R8
    dec_release_gain_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == SM_SHUT && state == SM_RISE) |-> gain == '0);

endmodule

// File: tb/smute_seq_bench.sv
`timescale 1ns/1ps
module smute_seq_bench;
    localparam int PMAX = 124;

    logic clk = 1'b0;
    logic rst;
    logic mute_pin_n, mute_en, dec_infl, src_is_dec, dec_force;
    logic [1:0] time_sel;
    logic [11:0] gain;
    logic busy, dec_mute;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    int divs [4] = '{1, 2, 3, 5};

    always #4 clk = ~clk;

    smute_seq #(.GAIN_W(12), .NPTS(32), .SUB_W(2),
                .DIV0(1), .DIV1(2), .DIV2(3), .DIV3(5)) u_smute_seq (
        .clk(clk), .rst(rst), .mute_pin_n(mute_pin_n), .mute_en(mute_en),
        .time_sel(time_sel), .dec_infl(dec_infl), .src_is_dec(src_is_dec),
        .dec_force(dec_force), .gain(gain), .busy(busy), .dec_mute(dec_mute)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nchk++; nerr++;
            $display("FAIL watchdog: run hung, actual=%0d expected<=150000", cyc);
            summary();
            $finish;
        end
    end

    function automatic int pt(input int j);
        longint jj;
        longint full;
        jj = j;
        full = 4095;
        return int'((full * (93 * jj * jj - 2 * jj * jj * jj)) / 29791);
    endfunction

    function automatic int exp_gain(input int p);
        int i, f, lo, hi;
        i  = p >> 2;
        f  = p & 3;
        lo = pt(i);
        hi = (i == 31) ? lo : pt(i + 1);
        return lo + ((hi - lo) * f) / 4;
    endfunction

    function automatic int dec_base();
        return (dec_force || !src_is_dec) ? 1 : 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Entered at the negedge where k = 0 of the ramp.
    task automatic ramp(input bit fall, input int lim, input int flip_k, input bit scramble);
        int last;
        int p;
        last = PMAX * lim;
        for (int k = 0; k <= last; k++) begin
            p = fall ? PMAX - k / lim : k / lim;
            chk("R3 R4 R11 gain", gain, exp_gain(p));
            if (fall) begin
                chk("R6 busy during fall", busy, 1);
                if (k == last)
                    chk("R7 R9 R10 dec at rest", dec_mute,
                        (dec_infl && src_is_dec) ? 1 : dec_base());
                else
                    chk("R9 R10 dec during fall", dec_mute, dec_base());
            end else begin
                chk("R6 busy during rise", busy, (k == last) ? 0 : 1);
                chk("R8 R9 R10 dec during rise", dec_mute, dec_base());
            end
            if (k == flip_k) mute_pin_n = ~mute_pin_n;
            if (scramble && k == lim) time_sel = ~time_sel;
            if (k < last) @(negedge clk);
        end
    endtask

    task automatic full_cycle(input int ts, input bit via_pin, input int ts_up);
        time_sel = 2'(ts);
        if (via_pin) mute_pin_n = 1'b0;
        else         mute_en = 1'b1;
        @(negedge clk);
        chk("R2 fall started", busy, 1);
        ramp(1'b1, divs[ts], -1, 1'b1);
        repeat (2) begin
            @(negedge clk);
            chk("R6 busy while held", busy, 1);
            chk("R4 gain held at zero", gain, 0);
        end
        time_sel = 2'(ts_up);
        mute_pin_n = 1'b1;
        mute_en = 1'b0;
        @(negedge clk);
        chk("R8 gain still zero at release", gain, 0);
        chk("R8 dec released at rise start", dec_mute, dec_base());
        ramp(1'b0, divs[ts_up], -1, 1'b1);
        @(negedge clk);
        chk("R6 idle after rise", busy, 0);
        chk("R6 gain full after rise", gain, 4095);
    endtask

    initial begin
        rst = 1'b1;
        mute_pin_n = 1'b1; mute_en = 1'b0; time_sel = 2'd0;
        dec_infl = 1'b1; src_is_dec = 1'b1; dec_force = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 gain after reset", gain, 4095);
        chk("R1 busy after reset", busy, 0);
        chk("R1 dec after reset", dec_mute, 0);

        repeat (5) @(negedge clk);
        chk("R2 no request keeps idle", busy, 0);
        chk("R2 no request keeps gain", gain, 4095);

        for (int ts = 0; ts < 4; ts++)
            full_cycle(ts, ts[0], (ts + 1) % 4);

        // R5: uninterruptible ramps in both directions
        time_sel = 2'd1;
        mute_pin_n = 1'b0;
        @(negedge clk);
        ramp(1'b1, 2, 40, 1'b0);
        @(negedge clk);
        chk("R5 rise follows finished fall", busy, 1);
        chk("R5 gain zero at rise start", gain, 0);
        ramp(1'b0, 2, 40, 1'b0);
        @(negedge clk);
        chk("R5 new fall follows finished rise", busy, 1);
        chk("R5 gain full at new fall start", gain, 4095);
        ramp(1'b1, 2, -1, 1'b0);
        mute_pin_n = 1'b1;
        @(negedge clk);
        ramp(1'b0, 2, -1, 1'b0);
        @(negedge clk);
        chk("R5 idle at end", busy, 0);

        // R7: influence off leaves decoder alone
        dec_infl = 1'b0;
        full_cycle(2, 1'b0, 0);

        // R10: other source selected
        dec_infl = 1'b1; src_is_dec = 1'b0;
        @(negedge clk);
        chk("R10 dec while idle", dec_mute, 1);
        full_cycle(0, 1'b1, 0);

        // R9: forced decoder mute
        src_is_dec = 1'b1; dec_force = 1'b1;
        @(negedge clk);
        chk("R9 dec while idle", dec_mute, 1);
        full_cycle(1, 1'b0, 0);
        dec_force = 1'b0;
        @(negedge clk);
        chk("R9 dec released with force off", dec_mute, 0);

        summary();
        $finish;
    end
endmodule